// File: doc/BRIEF.md
# Remote Management Request Controller

This block holds the software-visible controls for sending management-register accesses to the far end of a link. Software fills in a 5-bit target device code and a 16-bit target register address. It then raises a read-request bit, a write-request bit, or both. A small arbiter state machine turns each pending bit into one transfer toward a downstream transport, using a valid/ready handshake. It clears the request bit on the cycle the transport takes the transfer.

Requests leave only while the transmit enable is set. A read always goes out before a write that is pending at the same time. A write is allowed only after a matching unlock key has been written. Requests aimed at an unsupported device code are dropped. Requests refused for either reason raise sticky status flags that software clears. The receive enable bit is presented as a plain output for the receive path.

The arbiter has three states. `ST_IDLE` waits for a pending request and judges it. `ST_SEND_RD` presents a read transfer. `ST_SEND_WR` presents a write transfer. The transitions are:
- launch-read: `ST_IDLE` to `ST_SEND_RD`.
- launch-write: `ST_IDLE` to `ST_SEND_WR`.
- accept-read: `ST_SEND_RD` to `ST_IDLE`.
- accept-write: `ST_SEND_WR` to `ST_IDLE`.

A dropped request stays in `ST_IDLE` and clears its bit.

Top module: `rmgmt_req_ctrl`

## Requirements
- R1: After reset the control word reads 16'h0002 (transmit enable 0, receive enable 1, both request bits 0), the device code reads 5'h01, the register address reads 16'h0000, the key register reads 0 (locked), status reads 0, and no transfer is presented.
- R2: Control word (select 0) bits are: bit0 transmit enable, bit1 receive enable, bit2 read request, bit3 write request. Bits 15..4 ignore writes and read as zero.
- R3: No transfer is presented while transmit enable is 0. Pending request bits stay set until it becomes 1.
- R4: When read and write requests are pending together, the read transfer is accepted first and the write follows.
- R5: Writing 16'h5A17 to the key register (select 3) unlocks writes, and it then reads 1. Writing any other value locks again, and it reads 0. A write transfer is only ever presented while unlocked.
- R6: A write request made while locked is dropped without a transfer. Its bit clears, and status bit1 (lock violation) sets.
- R7: Device codes 1 to 4 are supported. A request to any other code is dropped without a transfer. Its bit clears, and status bit0 (bad device) sets.
- R8: While a transfer waits for ready, valid stays high and kind, device code and register address stay stable. The transfer carries the programmed device code (select 1) and register address (select 2).
- R9: A request bit clears in the cycle its transfer is accepted. It stays set while the transfer waits.
- R10: Status flags (select 4) are sticky and clear only when 1 is written to the flag's bit.
- R11: The rx_enable output follows control bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0 control, 1 device, 2 register address, 3 key, 4 status) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data for the selected register (combinational) |
| rx_enable | output | 1 | Receive feature enable |
| req_valid | output | 1 | Transfer presented to transport |
| req_ready | input | 1 | Transport accepts the transfer |
| req_is_write | output | 1 | 1 = write transfer, 0 = read transfer |
| req_dev | output | 5 | Target device code |
| req_reg | output | 16 | Target register address |

## Verification
The in-RTL properties watch every cycle for the following:
- a transfer starting without transmit enable;
- a write launching past a pending read;
- a write launching while locked;
- an unsupported device code on the transfer;
- payload changing under backpressure;
- a request bit surviving its acceptance;
- a status flag vanishing without a clear.

Only the directed scenarios can show that refused requests produce no transfer at all, that the order of read before write appears at the transport, and that reset values, reserved bits and key read-back are right.

// File: rtl/rmr_pkg.sv
package rmr_pkg;
    localparam int CFG_AW = 3;
    localparam int DATA_W = 16;
    localparam int DEV_W  = 5;

    localparam logic [CFG_AW-1:0] SEL_CTRL = 3'd0;
    localparam logic [CFG_AW-1:0] SEL_DEV  = 3'd1;
    localparam logic [CFG_AW-1:0] SEL_REG  = 3'd2;
    localparam logic [CFG_AW-1:0] SEL_KEY  = 3'd3;
    localparam logic [CFG_AW-1:0] SEL_STAT = 3'd4;

    localparam logic [DEV_W-1:0] DEV_LO = 5'd1;
    localparam logic [DEV_W-1:0] DEV_HI = 5'd4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND_RD = 2'd1,
        ST_SEND_WR = 2'd2
    } arb_state_t;

    function automatic logic dev_supported(input logic [DEV_W-1:0] d);
        return (d >= DEV_LO) && (d <= DEV_HI);
    endfunction
endpackage

// File: rtl/rmr_regs.sv
module rmr_regs
    import rmr_pkg::*;
#(
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h5A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              clr_rd,
    input  logic              clr_wr,
    input  logic              set_bad,
    input  logic              set_lockv,
    output logic              tx_en,
    output logic              rx_en,
    output logic              rd_req,
    output logic              wr_req,
    output logic [DEV_W-1:0]  dev_code,
    output logic [DATA_W-1:0] reg_addr,
    output logic              unlocked
);
    logic st_bad;
    logic st_lockv;
    logic wr_ctrl, wr_dev, wr_reg, wr_key, wr_stat;

    assign wr_ctrl = cfg_wr_en && (cfg_addr == SEL_CTRL);
    assign wr_dev  = cfg_wr_en && (cfg_addr == SEL_DEV);
    assign wr_reg  = cfg_wr_en && (cfg_addr == SEL_REG);
    assign wr_key  = cfg_wr_en && (cfg_addr == SEL_KEY);
    assign wr_stat = cfg_wr_en && (cfg_addr == SEL_STAT);

    // control word; the hardware clear takes precedence over a same-cycle software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            rx_en  <= 1'b1;
            rd_req <= 1'b0;
            wr_req <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                tx_en  <= cfg_wdata[0];
                rx_en  <= cfg_wdata[1];
                rd_req <= cfg_wdata[2];
                wr_req <= cfg_wdata[3];
            end
            if (clr_rd) rd_req <= 1'b0;
            if (clr_wr) wr_req <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_code <= 5'h01;
            reg_addr <= '0;
            unlocked <= 1'b0;
        end else begin
            if (wr_dev) dev_code <= cfg_wdata[DEV_W-1:0];
            if (wr_reg) reg_addr <= cfg_wdata;
            if (wr_key) unlocked <= (cfg_wdata == UNLOCK_KEY);
        end
    end

    // sticky flags: the write-one clear is applied first, so a same-cycle set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_bad   <= 1'b0;
            st_lockv <= 1'b0;
        end else begin
            if (wr_stat && cfg_wdata[0]) st_bad   <= 1'b0;
            if (wr_stat && cfg_wdata[1]) st_lockv <= 1'b0;
            if (set_bad)   st_bad   <= 1'b1;
            if (set_lockv) st_lockv <= 1'b1;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            SEL_CTRL: cfg_rdata[3:0] = {wr_req, rd_req, rx_en, tx_en};
            SEL_DEV:  cfg_rdata[DEV_W-1:0] = dev_code;
            SEL_REG:  cfg_rdata = reg_addr;
            SEL_KEY:  cfg_rdata[0] = unlocked;
            SEL_STAT: cfg_rdata[1:0] = {st_lockv, st_bad};
            default:  cfg_rdata = '0;
        endcase
    end

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |=> !rd_req);
    // R9
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !wr_req);
    // R10
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_bad && !(wr_stat && cfg_wdata[0])) |=> st_bad);
    // R10
    lockv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_lockv && !(wr_stat && cfg_wdata[1])) |=> st_lockv);
endmodule

// File: rtl/rmr_arbiter.sv
module rmr_arbiter
    import rmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              unlocked,
    input  logic [DEV_W-1:0]  dev_code,
    input  logic [DATA_W-1:0] reg_addr,
    output logic              clr_rd,
    output logic              clr_wr,
    output logic              set_bad,
    output logic              set_lockv,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_is_write,
    output logic [DEV_W-1:0]  req_dev,
    output logic [DATA_W-1:0] req_reg
);
    arb_state_t state, nxt;
    logic       load;
    logic       dev_ok;

    assign dev_ok = dev_supported(dev_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        clr_rd    = 1'b0;
        clr_wr    = 1'b0;
        set_bad   = 1'b0;
        set_lockv = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tx_en && rd_req) begin
                    if (dev_ok) begin
                        nxt  = ST_SEND_RD;
                        load = 1'b1;
                    end else begin
                        clr_rd  = 1'b1;
                        set_bad = 1'b1;
                    end
                end else if (tx_en && wr_req) begin
                    if (!unlocked) begin
                        clr_wr    = 1'b1;
                        set_lockv = 1'b1;
                    end else if (!dev_ok) begin
                        clr_wr  = 1'b1;
                        set_bad = 1'b1;
                    end else begin
                        nxt  = ST_SEND_WR;
                        load = 1'b1;
                    end
                end
            end
            ST_SEND_RD: if (req_ready) begin
                clr_rd = 1'b1;
                nxt    = ST_IDLE;
            end
            ST_SEND_WR: if (req_ready) begin
                clr_wr = 1'b1;
                nxt    = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // payload snapshot taken at launch so it holds under backpressure
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_dev <= '0;
            req_reg <= '0;
        end else if (load) begin
            req_dev <= dev_code;
            req_reg <= reg_addr;
        end
    end

    assign req_valid    = (state != ST_IDLE);
    assign req_is_write = (state == ST_SEND_WR);

    // R3
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(tx_en));
    // R4
    rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && $past(rd_req)) |-> !req_is_write);
    // R5
    wr_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_is_write) |-> $past(unlocked));
    // R7
    dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_dev >= DEV_LO && req_dev <= DEV_HI));
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_is_write)
                                       && $stable(req_dev) && $stable(req_reg)));
endmodule

// File: rtl/rmgmt_req_ctrl.sv
module rmgmt_req_ctrl
    import rmr_pkg::*;
#(
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h5A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              rx_enable,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_is_write,
    output logic [DEV_W-1:0]  req_dev,
    output logic [DATA_W-1:0] req_reg
);
    logic              tx_en, rx_en, rd_req, wr_req, unlocked;
    logic              clr_rd, clr_wr, set_bad, set_lockv;
    logic [DEV_W-1:0]  dev_code;
    logic [DATA_W-1:0] reg_addr;

    rmr_regs #(.UNLOCK_KEY(UNLOCK_KEY)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .clr_rd(clr_rd), .clr_wr(clr_wr),
        .set_bad(set_bad), .set_lockv(set_lockv),
        .tx_en(tx_en), .rx_en(rx_en), .rd_req(rd_req), .wr_req(wr_req),
        .dev_code(dev_code), .reg_addr(reg_addr), .unlocked(unlocked)
    );

    rmr_arbiter arb_i (
        .clk(clk), .rst_n(rst_n),
        .tx_en(tx_en), .rd_req(rd_req), .wr_req(wr_req),
        .unlocked(unlocked), .dev_code(dev_code), .reg_addr(reg_addr),
        .clr_rd(clr_rd), .clr_wr(clr_wr),
        .set_bad(set_bad), .set_lockv(set_lockv),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_write(req_is_write), .req_dev(req_dev), .req_reg(req_reg)
    );

    assign rx_enable = rx_en;
endmodule

// File: tb/rmgmt_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module rmgmt_req_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        rx_enable;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic        req_is_write;
    logic [4:0]  req_dev;
    logic [15:0] req_reg;

    int n_chk = 0;
    int n_fail = 0;
    int acc_cnt = 0;
    logic        acc_wr  [16];
    logic [4:0]  acc_dev [16];
    logic [15:0] acc_reg [16];

    always #2.5 clk = ~clk;

    rmgmt_req_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rx_enable(rx_enable),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_write(req_is_write), .req_dev(req_dev), .req_reg(req_reg)
    );

    // transport-side log of accepted transfers
    always @(posedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            acc_wr[acc_cnt[3:0]]  <= req_is_write;
            acc_dev[acc_cnt[3:0]] <= req_dev;
            acc_reg[acc_cnt[3:0]] <= req_reg;
            acc_cnt <= acc_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_acc(input int target);
        for (int i = 0; i < 50 && acc_cnt < target; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(3'd0, 16'h0002, "R1 ctrl");
        rd_chk(3'd1, 16'h0001, "R1 dev");
        rd_chk(3'd2, 16'h0000, "R1 reg");
        rd_chk(3'd3, 16'h0000, "R1 key");
        rd_chk(3'd4, 16'h0000, "R1 status");
        chk(req_valid == 1'b0, "R1 valid", req_valid, 0);
        chk(rx_enable == 1'b1, "R11 rx reset", rx_enable, 1);
    endtask

    task automatic t_reserved();
        wr(3'd0, 16'hFFF2);
        rd_chk(3'd0, 16'h0002, "R2 reserved zero");
        wr(3'd0, 16'h0000);
        chk(rx_enable == 1'b0, "R11 rx off", rx_enable, 0);
        wr(3'd0, 16'h0002);
        chk(rx_enable == 1'b1, "R11 rx on", rx_enable, 1);
    endtask

    task automatic t_tx_gate();
        int base = acc_cnt;
        wr(3'd1, 16'h0002);
        wr(3'd2, 16'h1234);
        wr(3'd0, 16'h0006);
        idle(6);
        chk(req_valid == 1'b0, "R3 no valid", req_valid, 0);
        chk(acc_cnt == base, "R3 no transfer", acc_cnt, base);
        rd_chk(3'd0, 16'h0006, "R3 still pending");
        wr(3'd0, 16'h0007);
        wait_acc(base + 1);
        idle(1);
        chk(acc_cnt == base + 1, "R3 sent", acc_cnt, base + 1);
        chk(acc_wr[base] == 1'b0, "R8 kind read", acc_wr[base], 0);
        chk(acc_dev[base] == 5'd2, "R8 dev", acc_dev[base], 2);
        chk(acc_reg[base] == 16'h1234, "R8 reg", acc_reg[base], 16'h1234);
        rd_chk(3'd0, 16'h0003, "R9 rd cleared");
    endtask

    task automatic t_locked();
        int base = acc_cnt;
        wr(3'd0, 16'h000B);
        idle(6);
        chk(acc_cnt == base, "R6 no transfer", acc_cnt, base);
        rd_chk(3'd0, 16'h0003, "R6 wr dropped");
        rd_chk(3'd4, 16'h0002, "R6 lock flag");
        idle(4);
        rd_chk(3'd4, 16'h0002, "R10 sticky");
        wr(3'd4, 16'h0001);
        rd_chk(3'd4, 16'h0002, "R10 other bit kept");
        wr(3'd4, 16'h0002);
        rd_chk(3'd4, 16'h0000, "R10 cleared");
    endtask

    task automatic t_unlock_write();
        int base = acc_cnt;
        wr(3'd3, 16'h1111);
        rd_chk(3'd3, 16'h0000, "R5 wrong key");
        wr(3'd3, 16'h5A17);
        rd_chk(3'd3, 16'h0001, "R5 unlocked");
        wr(3'd1, 16'h0004);
        wr(3'd2, 16'hBEEF);
        wr(3'd0, 16'h000B);
        wait_acc(base + 1);
        idle(1);
        chk(acc_cnt == base + 1, "R5 write sent", acc_cnt, base + 1);
        chk(acc_wr[base] == 1'b1, "R5 kind write", acc_wr[base], 1);
        chk(acc_dev[base] == 5'd4, "R8 dev4", acc_dev[base], 4);
        chk(acc_reg[base] == 16'hBEEF, "R8 reg beef", acc_reg[base], 16'hBEEF);
        rd_chk(3'd0, 16'h0003, "R9 wr cleared");
    endtask

    task automatic t_priority();
        int base = acc_cnt;
        wr(3'd0, 16'h000F);
        wait_acc(base + 2);
        idle(1);
        chk(acc_cnt == base + 2, "R4 two sent", acc_cnt, base + 2);
        chk(acc_wr[base] == 1'b0, "R4 read first", acc_wr[base], 0);
        chk(acc_wr[base+1] == 1'b1, "R4 write second", acc_wr[base+1], 1);
        rd_chk(3'd0, 16'h0003, "R4 both cleared");
    endtask

    task automatic t_bad_dev();
        int base = acc_cnt;
        wr(3'd1, 16'h0005);
        wr(3'd0, 16'h0007);
        idle(6);
        chk(acc_cnt == base, "R7 read dropped", acc_cnt, base);
        rd_chk(3'd0, 16'h0003, "R7 rd cleared");
        rd_chk(3'd4, 16'h0001, "R7 bad flag");
        wr(3'd4, 16'h0001);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h000B);
        idle(6);
        chk(acc_cnt == base, "R7 write dropped", acc_cnt, base);
        rd_chk(3'd4, 16'h0001, "R7 bad flag write");
        wr(3'd4, 16'h0003);
    endtask

    task automatic t_backpressure();
        int base = acc_cnt;
        bit hold_ok = 1'b1;
        req_ready = 1'b0;
        wr(3'd1, 16'h0003);
        wr(3'd2, 16'h00A5);
        wr(3'd0, 16'h0007);
        idle(1);
        for (int i = 0; i < 5; i++) begin
            if (!(req_valid && !req_is_write && req_dev == 5'd3 && req_reg == 16'h00A5))
                hold_ok = 1'b0;
            @(negedge clk);
        end
        chk(hold_ok, "R8 held under backpressure", hold_ok, 1);
        rd_chk(3'd0, 16'h0007, "R9 bit held while waiting");
        req_ready = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R8 released", req_valid, 0);
        chk(acc_cnt == base + 1, "R8 one accept", acc_cnt, base + 1);
        rd_chk(3'd0, 16'h0003, "R9 cleared on accept");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_reserved();
        t_tx_gate();
        t_locked();
        t_unlock_write();
        t_priority();
        t_bad_dev();
        t_backpressure();
        idle(2);
        summary();
    end
endmodule